// File: doc/BRIEF.md
# Real-time clock register block with committed writes

This block keeps time for an always-on power domain and sits on a simple word-addressed register bus. It counts sub-second ticks in a fractional counter that wraps at a configurable prescale value and carries into a 32-bit seconds counter. A 64-bit alarm compare raises a sticky alarm flag, and a single interrupt line collects every status flag that software has enabled.

Bus writes do not land at once. Each accepted write enters a commit stage that holds the value for a fixed latency while a busy flag shows, and then applies it and raises a done flag. Software polls these flags, or takes the interrupt, before it issues the next write. A write that arrives while a commit is still running is dropped and flagged as an error. The time counter stays frozen until its seconds word has been written once and the run bit is set, so a freshly powered block reads a stable zero time.

Top module: `rtc_handshake`

## Requirements
- R1: After reset the status word reads 0x202 (ready bit 9 and invalid bit 1 set). Seconds, fraction, alarm low, control and interrupt mask read 0, alarm high reads 0xFFFFFFFF and irq_o is 0.
- R2: A write accepted while bit 10 (busy) is clear sets busy from the next cycle for COMMIT_LAT cycles. Only after that is the value visible in its register, with busy clear and bit 8 (done) set.
- R3: A write presented while busy is set is rejected. Bit 7 (error) is set and neither the target register nor the pending commit changes.
- R4: Done (bit 8) clears in the cycle after the next write is accepted.
- R5: A committed write to the status word (index 5) clears error (bit 7), alarm (bit 4) and violation (bit 0) where the data bit is one. Invalid (bit 1) clears only when data bits 1 and 0 are both one. A flag being set in the same cycle wins over the clear.
- R6: The counters do not advance until the seconds word (index 0) has been committed at least once and control bit 3 (run) is one.
- R7: While running, each tick_i pulse increments the fraction (index 1). When the fraction equals FRAC_WRAP-1 it wraps to 0 and seconds increments. A commit to index 0 or 1 suppresses counting in its cycle.
- R8: When alarm high (index 2) is not all ones and {seconds, fraction} equals {alarm high, alarm low (index 3)}, the alarm flag (bit 4) is set one cycle later and holds until cleared.
- R9: irq_o is one exactly when some status bit among 9, 8, 7, 4 is set together with the same bit of the interrupt mask (index 6).
- R10: Ready (bit 9) reads as the inverse of busy.
- R11: Control keeps only bit 3 and the mask keeps only bits 9, 8, 7, 4. Index 7 reads 0, and a write to it commits without changing any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle fractional tick |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Word index for read and write |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data of the indexed word, combinational |
| irq_o | output | 1 | Interrupt, OR of enabled flags |

## Verification
Read data and irq_o follow the register state within the same cycle. A write's effect appears only at the COMMIT_LAT-th edge after the edge that accepted it, while busy, ready and done change one edge after acceptance. The alarm flag follows a counter match by one edge, and a count step by one edge after the tick. The bench drives every input just after a falling edge, settles for 1 ns, compares the indexed word and irq_o against a behavioural model advanced once per rising edge, and places each literal expectation at the exact cycle these latencies predict.

// File: rtl/rtc_hs_pkg.sv
package rtc_hs_pkg;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] IDX_SEC    = 3'd0;
  localparam logic [AW-1:0] IDX_FRAC   = 3'd1;
  localparam logic [AW-1:0] IDX_ALM_HI = 3'd2;
  localparam logic [AW-1:0] IDX_ALM_LO = 3'd3;
  localparam logic [AW-1:0] IDX_CTRL   = 3'd4;
  localparam logic [AW-1:0] IDX_STAT   = 3'd5;
  localparam logic [AW-1:0] IDX_IEN    = 3'd6;

  localparam int unsigned BIT_BUSY = 10;
  localparam int unsigned BIT_RDY  = 9;
  localparam int unsigned BIT_DONE = 8;
  localparam int unsigned BIT_ERR  = 7;
  localparam int unsigned BIT_ALM  = 4;
  localparam int unsigned BIT_INV  = 1;
  localparam int unsigned BIT_VIOL = 0;
  localparam int unsigned BIT_RUN  = 3;
endpackage

// File: rtl/rtc_hs_commit.sv
module rtc_hs_commit #(
  parameter int unsigned LAT = 4,
  parameter int unsigned AW  = 3,
  parameter int unsigned DW  = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          reject_o,
  output logic          commit_o,
  output logic [AW-1:0] c_addr_o,
  output logic [DW-1:0] c_data_o
);
  localparam int unsigned CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LAT);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic          busy_q, busy_d, done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          accept, fire;

  always_comb begin
    accept = wr_i && !busy_q;
    fire   = busy_q && (cnt_q == CNT_LAST);
    busy_d = busy_q;
    done_d = done_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      cnt_d  = CNT_ONE;
    end else if (fire) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= addr_i;
      data_q <= wdata_i;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign reject_o = wr_i && busy_q;
  assign commit_o = fire;
  assign c_addr_o = addr_q;
  assign c_data_o = data_q;

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> busy_o);
  p_commit_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (!busy_o && done_o));
  p_done_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> !done_o);
  p_pending_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !commit_o) |=> ($stable(c_addr_o) && $stable(c_data_o)));
endmodule

// File: rtl/rtc_hs_timebase.sv
module rtc_hs_timebase #(
  parameter int unsigned DW        = 32,
  parameter int unsigned FRAC_WRAP = 32768
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          ld_sec_i,
  input  logic          ld_frac_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic [DW-1:0] alm_hi_i,
  input  logic [DW-1:0] alm_lo_i,
  output logic [DW-1:0] sec_o,
  output logic [DW-1:0] frac_o,
  output logic          alarm_hit_o
);
  localparam logic [DW-1:0] FRAC_LAST = DW'(FRAC_WRAP - 1);
  localparam logic [DW-1:0] ONE       = DW'(1);

  logic          armed_q;
  logic [DW-1:0] sec_q, sec_d, frac_q, frac_d;
  logic          count_en, wrap, sec_en, frac_en;

  always_comb begin
    count_en = run_i && armed_q && tick_i && !ld_sec_i && !ld_frac_i;
    wrap     = (frac_q == FRAC_LAST);
    sec_en   = ld_sec_i || (count_en && wrap);
    frac_en  = ld_frac_i || count_en;
    sec_d    = ld_sec_i ? ld_val_i : sec_q + ONE;
    frac_d   = ld_frac_i ? ld_val_i : (wrap ? '0 : frac_q + ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sec_q <= '0;
    else if (sec_en) sec_q <= sec_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frac_q <= '0;
    else if (frac_en) frac_q <= frac_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (ld_sec_i) armed_q <= 1'b1;
  end

  assign sec_o       = sec_q;
  assign frac_o      = frac_q;
  assign alarm_hit_o = (alm_hi_i != '1) && (sec_q == alm_hi_i) && (frac_q == alm_lo_i);

  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !ld_frac_i && !ld_sec_i) |=> ($stable(frac_o) && $stable(sec_o)));
  p_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_en && frac_o == FRAC_LAST) |=> (frac_o == '0 && sec_o == $past(sec_o) + ONE));
endmodule

// File: rtl/rtc_handshake.sv
module rtc_handshake
  import rtc_hs_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned FRAC_WRAP  = 32768,
  parameter int unsigned COMMIT_LAT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          bus_wr_i,
  input  logic [2:0]    bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  localparam logic [DW-1:0] IEN_MASK =
    DW'((1 << BIT_RDY) | (1 << BIT_DONE) | (1 << BIT_ERR) | (1 << BIT_ALM));

  logic [1:0]    rst_sync_q;
  logic          rst_n;
  logic          busy, done, reject, commit, hit;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data, sec, frac;
  logic [DW-1:0] alm_hi_q, alm_lo_q, ien_q, stat;
  logic          run_q, err_q, alm_q, inv_q, viol_q;
  logic          err_d, alm_d, inv_d, viol_d, stat_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  rtc_hs_commit #(.LAT(COMMIT_LAT), .AW(AW), .DW(DW)) u_commit (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .busy_o(busy), .done_o(done), .reject_o(reject),
    .commit_o(commit), .c_addr_o(c_addr), .c_data_o(c_data)
  );

  rtc_hs_timebase #(.DW(DW), .FRAC_WRAP(FRAC_WRAP)) u_time (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run_q), .tick_i(tick_i),
    .ld_sec_i(commit && c_addr == IDX_SEC), .ld_frac_i(commit && c_addr == IDX_FRAC),
    .ld_val_i(c_data), .alm_hi_i(alm_hi_q), .alm_lo_i(alm_lo_q),
    .sec_o(sec), .frac_o(frac), .alarm_hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) alm_hi_q <= '1;
    else if (commit && c_addr == IDX_ALM_HI) alm_hi_q <= c_data;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) alm_lo_q <= '0;
    else if (commit && c_addr == IDX_ALM_LO) alm_lo_q <= c_data;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else if (commit && c_addr == IDX_CTRL) run_q <= c_data[BIT_RUN];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else if (commit && c_addr == IDX_IEN) ien_q <= c_data & IEN_MASK;
  end

  always_comb begin
    stat_wr = commit && (c_addr == IDX_STAT);
    err_d   = reject || (err_q && !(stat_wr && c_data[BIT_ERR]));
    alm_d   = hit || (alm_q && !(stat_wr && c_data[BIT_ALM]));
    inv_d   = inv_q && !(stat_wr && c_data[BIT_INV] && c_data[BIT_VIOL]);
    viol_d  = viol_q && !(stat_wr && c_data[BIT_VIOL]);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      alm_q  <= 1'b0;
      inv_q  <= 1'b1;
      viol_q <= 1'b0;
    end else begin
      err_q  <= err_d;
      alm_q  <= alm_d;
      inv_q  <= inv_d;
      viol_q <= viol_d;
    end
  end

  always_comb begin
    stat           = '0;
    stat[BIT_BUSY] = busy;
    stat[BIT_RDY]  = !busy;
    stat[BIT_DONE] = done;
    stat[BIT_ERR]  = err_q;
    stat[BIT_ALM]  = alm_q;
    stat[BIT_INV]  = inv_q;
    stat[BIT_VIOL] = viol_q;
  end

  always_comb begin
    case (bus_addr_i)
      IDX_SEC:    bus_rdata_o = sec;
      IDX_FRAC:   bus_rdata_o = frac;
      IDX_ALM_HI: bus_rdata_o = alm_hi_q;
      IDX_ALM_LO: bus_rdata_o = alm_lo_q;
      IDX_CTRL:   bus_rdata_o = DW'(run_q) << BIT_RUN;
      IDX_STAT:   bus_rdata_o = stat;
      IDX_IEN:    bus_rdata_o = ien_q;
      default:    bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat & ien_q);

  p_reject_err_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_wr_i && busy) |=> err_q);
  p_alarm_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (alm_q && !(commit && c_addr == IDX_STAT && c_data[BIT_ALM])) |=> alm_q);
  p_alarm_set_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit |=> alm_q);
  p_inv_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (inv_q && !(commit && c_addr == IDX_STAT && c_data[BIT_INV] && c_data[BIT_VIOL])) |=> inv_q);
endmodule

// File: tb/test_rtc_handshake.sv
`timescale 1ns/1ps
module test_rtc_handshake;
  localparam int PRE = 4;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rtc_handshake #(.DW(32), .FRAC_WRAP(PRE), .COMMIT_LAT(LAT)) i_rtc_handshake (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural model state
  logic [31:0] m_sec = 0, m_frac = 0, m_ahi = 32'hFFFF_FFFF, m_alo = 0, m_ien = 0, m_pdata = 0;
  logic [2:0]  m_paddr = 0;
  logic        m_run = 0, m_armed = 0, m_busy = 0, m_done = 0;
  logic        m_err = 0, m_alm = 0, m_inv = 1, m_viol = 0;
  int          m_cnt = 0;

  function automatic logic [31:0] m_stat();
    return (32'(m_busy) << 10) | (32'(!m_busy) << 9) | (32'(m_done) << 8) |
           (32'(m_err) << 7) | (32'(m_alm) << 4) | (32'(m_inv) << 1) | 32'(m_viol);
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_sec;
      3'd1: return m_frac;
      3'd2: return m_ahi;
      3'd3: return m_alo;
      3'd4: return 32'(m_run) << 3;
      3'd5: return m_stat();
      3'd6: return m_ien;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    if (a <= 3'd1) return "R7";
    if (a == 3'd5) return "R2";
    if (a == 3'd2 || a == 3'd3) return "R8";
    return "R11";
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic step(input logic t, input logic w, input logic [2:0] a, input logic [31:0] d,
                      input bit chk_en, input logic [31:0] exp, input string tag, input int exp_irq);
    logic acc, rej, fire, swr, hit, cnt_en;
    logic [31:0] n_sec, n_frac;
    @(negedge clk);
    tick = t; wr = w; addr = a; wdata = d;
    #1;
    check(rdata, m_read(a), tag_of(a));
    check(32'(irq), 32'(|(m_stat() & m_ien)), "R9");
    if (chk_en) check(rdata, exp, tag);
    if (exp_irq >= 0) check(32'(irq), 32'(exp_irq), "R9");
    acc    = w && !m_busy;
    rej    = w && m_busy;
    fire   = m_busy && (m_cnt == LAT);
    swr    = fire && (m_paddr == 3'd5);
    hit    = (m_ahi != 32'hFFFF_FFFF) && (m_sec == m_ahi) && (m_frac == m_alo);
    cnt_en = m_run && m_armed && t && !(fire && (m_paddr <= 3'd1));
    n_sec  = m_sec;
    n_frac = m_frac;
    if (cnt_en) begin
      if (m_frac == 32'(PRE - 1)) begin n_frac = 0; n_sec = m_sec + 1; end
      else n_frac = m_frac + 1;
    end
    @(posedge clk);
    if (hit) m_alm = 1;
    else if (swr && m_pdata[4]) m_alm = 0;
    if (rej) m_err = 1;
    else if (swr && m_pdata[7]) m_err = 0;
    if (swr && m_pdata[1] && m_pdata[0]) m_inv = 0;
    if (swr && m_pdata[0]) m_viol = 0;
    m_sec = n_sec;
    m_frac = n_frac;
    if (fire) begin
      case (m_paddr)
        3'd0: begin m_sec = m_pdata; m_armed = 1; end
        3'd1: m_frac = m_pdata;
        3'd2: m_ahi = m_pdata;
        3'd3: m_alo = m_pdata;
        3'd4: m_run = m_pdata[3];
        3'd6: m_ien = m_pdata & 32'h0000_0390;
        default: ;
      endcase
    end
    if (acc) begin
      m_busy = 1; m_done = 0; m_cnt = 1; m_paddr = a; m_pdata = d;
    end else if (fire) begin
      m_busy = 0; m_done = 1; m_cnt = 0;
    end else if (m_busy) m_cnt++;
  endtask

  task automatic idle(input logic [2:0] a);
    step(0, 0, a, 0, 0, 0, "", -1);
  endtask
  task automatic look(input logic [2:0] a, input logic [31:0] exp, input string tag);
    step(0, 0, a, 0, 1, exp, tag, -1);
  endtask
  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    step(0, 1, a, d, 0, 0, "", -1);
    repeat (LAT) idle(3'd5);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle(3'd5);

    // R1 reset values
    step(0, 0, 3'd5, 0, 1, 32'h202, "R1", 0);
    look(3'd0, 32'h0, "R1");
    look(3'd1, 32'h0, "R1");
    look(3'd2, 32'hFFFF_FFFF, "R1");
    look(3'd4, 32'h0, "R1");
    look(3'd6, 32'h0, "R1");

    // R2 / R10 first commit, R11 mask
    step(0, 1, 3'd6, 32'hFFFF_FFFF, 0, 0, "", -1);
    look(3'd5, 32'h402, "R10");
    look(3'd6, 32'h0, "R2");
    repeat (LAT - 2) idle(3'd5);
    look(3'd6, 32'h390, "R11");
    step(0, 0, 3'd5, 0, 1, 32'h302, "R2", 1);

    // R6 frozen before seconds written
    wreg(3'd4, 32'h8);
    repeat (5) step(1, 0, 3'd1, 0, 0, 0, "", -1);
    look(3'd1, 32'h0, "R6");
    look(3'd0, 32'h0, "R6");

    // R7 counting and carry
    wreg(3'd0, 32'h100);
    repeat (PRE) step(1, 0, 3'd1, 0, 0, 0, "", -1);
    look(3'd0, 32'h101, "R7");
    look(3'd1, 32'h0, "R7");

    // R3 rejected write
    step(0, 1, 3'd0, 32'h200, 0, 0, "", -1);
    step(0, 1, 3'd1, 32'hAA, 0, 0, "", -1);
    repeat (LAT - 1) idle(3'd5);
    look(3'd0, 32'h200, "R3");
    look(3'd1, 32'h0, "R3");
    look(3'd5, 32'h382, "R3");

    // R4 done clears, R5 error clear
    step(0, 1, 3'd5, 32'h80, 0, 0, "", -1);
    look(3'd5, 32'h482, "R4");
    repeat (LAT - 1) idle(3'd5);
    look(3'd5, 32'h302, "R5");
    wreg(3'd5, 32'h2);
    look(3'd5, 32'h302, "R5");
    wreg(3'd5, 32'h3);
    look(3'd5, 32'h300, "R5");

    // R8 alarm match and stickiness
    wreg(3'd3, 32'h2);
    wreg(3'd2, 32'h200);
    step(1, 0, 3'd1, 0, 0, 0, "", -1);
    step(1, 0, 3'd1, 0, 0, 0, "", -1);
    idle(3'd5);
    step(0, 0, 3'd5, 0, 1, 32'h310, "R8", 1);
    repeat (2) step(1, 0, 3'd5, 0, 0, 0, "", -1);
    look(3'd5, 32'h310, "R8");
    wreg(3'd5, 32'h10);
    look(3'd5, 32'h300, "R5");

    // R11 unused index and control bits
    wreg(3'd7, 32'hFFFF_FFFF);
    look(3'd7, 32'h0, "R11");
    look(3'd0, 32'h201, "R11");
    look(3'd5, 32'h300, "R11");
    wreg(3'd4, 32'hFFFF_FFFF);
    look(3'd4, 32'h8, "R11");

    // mixed traffic against the model
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 800; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[4], lfsr[2:0] == 3'd0, lfsr[10:8],
           (lfsr[10:8] == 3'd4) ? {lfsr[31:4], 1'b1, lfsr[2:0]} : {16'h0, lfsr[27:12]},
           0, 0, "", -1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule